// File: doc/BRIEF.md
# Battery-Backed Power Mode Controller

This controller moves a metering system-on-chip between four operating modes. Full-power mode runs from system power. Three modes run from the battery: battery-run, display-only and rest. In battery-run most digital functions stay up on a reduced clock. In display-only mode the display, the real-time clock and the wake timer keep running. In rest mode only the real-time clock and the wake timer keep running. The controller turns each function on or off, selects the processor clock source and passes a divider setting to the full-power clock path.

Software asks for display-only or rest mode by writing request bits to a control register. That request only acts while the part is in battery-run mode without system power. The part leaves display-only or rest mode in only three ways: a wake-timer timeout, a pushbutton press, or the return of system power. If the battery regulator loses its headroom while there is no system power, the controller forces rest mode. It stays in rest mode after the headroom comes back, until a wake event arrives. Pushbutton and wake events also set sticky interrupt flags, which software clears by writing zero.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted and in the cycles after it is released, the mode is rest (code 3), both flags read 0, the divider output is 0, only the clock and wake-timer enables are on, the clock select is 1 and the processor-run output is 0.
- R2: A cycle with `sys_pwr_i` high puts the controller in full-power mode (code 0) at the next clock edge, whatever the current mode and whatever `bat_ok_i` is.
- R3: In full-power mode, when `sys_pwr_i` goes low and `bat_ok_i` is high, the next mode is battery-run (code 1).
- R4: A write to the control register (address 9) acts on the mode only in battery-run mode. Bit 6 requests rest (code 3). Bit 5 requests display-only (code 2). When both bits are set, rest wins. The same write made in display-only or rest mode does not change the mode.
- R5: A control register write made while `sys_pwr_i` is high leaves the mode in full-power.
- R6: When `sys_pwr_i` is low and `bat_ok_i` is low, the next mode is rest. The mode stays rest after `bat_ok_i` goes high again, until a wake event or system power arrives.
- R7: With no system power, a wake-timer pulse or a pushbutton rising edge moves display-only or rest mode to battery-run. In battery-run these events do not change the mode.
- R8: `pbtn_i` passes through two synchronizer flops. Its rising edge sets the pushbutton flag (flag register bit 4) on the third clock edge after the pin goes high. Holding the pin high does not set the flag again after it has been cleared.
- R9: A cycle with `wake_tmo_i` high sets the wake flag (flag register bit 5) at the next edge. A write to the flag register (address 8) clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. A set in the same cycle as a clear wins.
- R10: `func_en_o` bits are: 0 clock, 1 wake timer, 2 display, 3 UART, 4 EEPROM, 5 metering. They read 6'h3F in full-power, 6'h1F in battery-run, 6'h07 in display-only and 6'h03 in rest.
- R11: `clk_sel_o` is 0 (PLL) only in full-power mode and 1 (7/8 of the 32768 Hz crystal) otherwise. `mpu_run_o` is 1 in full-power and battery-run and 0 in display-only and rest.
- R12: Each control register write loads bits [2:0] into `mpu_div_o` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sys_pwr_i | input | 1 | System power present |
| bat_ok_i | input | 1 | Battery regulator has enough headroom |
| pbtn_i | input | 1 | Pushbutton pin, asynchronous, high when pressed |
| wake_tmo_i | input | 1 | Wake-timer timeout pulse, synchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| mode_o | output | 2 | Current mode: 0 full-power, 1 battery-run, 2 display-only, 3 rest |
| func_en_o | output | 6 | Per-function enables |
| clk_sel_o | output | 1 | Processor clock source select |
| mpu_run_o | output | 1 | Processor clock running |
| mpu_div_o | output | 3 | Divider setting for the full-power clock |
| pb_flag_o | output | 1 | Sticky pushbutton interrupt flag |
| wake_flag_o | output | 1 | Sticky wake interrupt flag |

## Verification
The bench drops battery headroom and then restores it, to check that rest mode holds. A design that exits when `bat_ok_i` returns would wake the part with no wake event. It sends mode requests while system power is present and while the part is already in display-only mode; a faulty decoder would drop the part into a low-power mode at the wrong time. It checks the pushbutton flag one edge before and on the edge where it should set, then clears the flag while the pin is still held. A level-sensitive flag would set again at once, and a missing synchronizer stage would shift the timing. It also issues a flag clear in the same cycle as a wake pulse, which catches a design that lets the clear win.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  // Mode codes double as a depth rank: a larger code powers fewer functions.
  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_BATT = 2'd1,
    MODE_DISP = 2'd2,
    MODE_REST = 2'd3
  } pmode_t;

  localparam int FN_COUNT  = 6;
  localparam int FN_CLOCK  = 0;
  localparam int FN_WTIMER = 1;
  localparam int FN_DISP   = 2;
  localparam int FN_UART   = 3;
  localparam int FN_EEPROM = 4;
  localparam int FN_METER  = 5;

  // Deepest mode in which a function still runs.
  function automatic logic [1:0] fn_deepest(input int idx);
    case (idx)
      FN_CLOCK, FN_WTIMER: fn_deepest = MODE_REST;
      FN_DISP:             fn_deepest = MODE_DISP;
      FN_UART, FN_EEPROM:  fn_deepest = MODE_BATT;
      default:             fn_deepest = MODE_FULL;
    endcase
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_btn_sync.sv
module pwr_btn_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[SH_W-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  // Newest synchronized sample high, previous one low.
  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/pwr_ctrl_regs.sv
module pwr_ctrl_regs #(
  parameter int          ADDR_W    = 4,
  parameter int          DATA_W    = 8,
  parameter int          DIV_W     = 3,
  parameter logic [3:0]  CTRL_ADDR = 4'h9,
  parameter logic [3:0]  FLAG_ADDR = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pb_evt_i,
  input  logic              wake_evt_i,
  output logic              rest_req_o,
  output logic              disp_req_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              pb_flag_o,
  output logic              wake_flag_o
);
  localparam int REST_BIT = 6;
  localparam int DISP_BIT = 5;
  localparam int PB_BIT   = 4;
  localparam int WK_BIT   = 5;

  logic             ctrl_hit;
  logic             flag_hit;
  logic [DIV_W-1:0] div_q, div_nxt;
  logic             div_en;
  logic             pb_q, pb_nxt;
  logic             wk_q, wk_nxt;
  logic             flag_en;

  assign ctrl_hit = wr_i && (addr_i == ADDR_W'(CTRL_ADDR));
  assign flag_hit = wr_i && (addr_i == ADDR_W'(FLAG_ADDR));

  // Requests are one-cycle pulses, not stored.
  assign rest_req_o = ctrl_hit & wdata_i[REST_BIT];
  assign disp_req_o = ctrl_hit & wdata_i[DISP_BIT];

  always_comb begin
    div_en  = ctrl_hit;
    div_nxt = wdata_i[DIV_W-1:0];
  end

  always_comb begin
    flag_en = flag_hit | pb_evt_i | wake_evt_i;
    pb_nxt  = pb_evt_i   | (pb_q & (~flag_hit | wdata_i[PB_BIT]));
    wk_nxt  = wake_evt_i | (wk_q & (~flag_hit | wdata_i[WK_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_en) begin
      div_q <= div_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_q <= 1'b0;
      wk_q <= 1'b0;
    end else if (flag_en) begin
      pb_q <= pb_nxt;
      wk_q <= wk_nxt;
    end
  end

  assign div_o       = div_q;
  assign pb_flag_o   = pb_q;
  assign wake_flag_o = wk_q;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sys_pwr_i,
  input  logic   bat_ok_i,
  input  logic   wake_i,
  input  logic   rest_req_i,
  input  logic   disp_req_i,
  output pmode_t mode_o
);
  pmode_t mode_q, mode_nxt;
  logic   mode_en;

  always_comb begin
    mode_nxt = mode_q;
    if (sys_pwr_i) begin
      mode_nxt = MODE_FULL;
    end else if (!bat_ok_i) begin
      mode_nxt = MODE_REST;
    end else begin
      case (mode_q)
        MODE_FULL: mode_nxt = MODE_BATT;
        MODE_BATT: begin
          if (rest_req_i)      mode_nxt = MODE_REST;
          else if (disp_req_i) mode_nxt = MODE_DISP;
        end
        MODE_DISP, MODE_REST: begin
          if (wake_i) mode_nxt = MODE_BATT;
        end
        default: mode_nxt = MODE_REST;
      endcase
    end
    mode_en = (mode_nxt != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_REST;
    else if (mode_en) mode_q <= mode_nxt;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pwr_fn_decode.sv
module pwr_fn_decode
  import pwr_mode_pkg::*;
(
  input  pmode_t              mode_i,
  output logic [FN_COUNT-1:0] fn_en_o,
  output logic                clk_sel_o,
  output logic                mpu_run_o
);
  for (genvar g = 0; g < FN_COUNT; g++) begin : g_fn
    localparam logic [1:0] DEEP = fn_deepest(g);
    assign fn_en_o[g] = (mode_i <= DEEP);
  end

  assign clk_sel_o = (mode_i != MODE_FULL);
  assign mpu_run_o = (mode_i <= MODE_BATT);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter int         DATA_W      = 8,
  parameter int         DIV_W       = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         RST_STAGES  = 2,
  parameter logic [3:0] CTRL_ADDR   = 4'h9,
  parameter logic [3:0] FLAG_ADDR   = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_pwr_i,
  input  logic              bat_ok_i,
  input  logic              pbtn_i,
  input  logic              wake_tmo_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [1:0]        mode_o,
  output logic [5:0]        func_en_o,
  output logic              clk_sel_o,
  output logic              mpu_run_o,
  output logic [DIV_W-1:0]  mpu_div_o,
  output logic              pb_flag_o,
  output logic              wake_flag_o
);
  logic   rst_sync_n;
  logic   pb_evt;
  logic   rest_req, disp_req;
  pmode_t mode;

  pwr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pwr_btn_sync #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(pbtn_i), .rise_o(pb_evt)
  );

  pwr_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
    .CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .pb_evt_i(pb_evt), .wake_evt_i(wake_tmo_i),
    .rest_req_o(rest_req), .disp_req_o(disp_req),
    .div_o(mpu_div_o), .pb_flag_o(pb_flag_o), .wake_flag_o(wake_flag_o)
  );

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .sys_pwr_i(sys_pwr_i), .bat_ok_i(bat_ok_i),
    .wake_i(pb_evt | wake_tmo_i),
    .rest_req_i(rest_req), .disp_req_i(disp_req),
    .mode_o(mode)
  );

  pwr_fn_decode u_dec (
    .mode_i(mode), .fn_en_o(func_en_o),
    .clk_sel_o(clk_sel_o), .mpu_run_o(mpu_run_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_pwr_i,
  input logic       bat_ok_i,
  input logic       wake_tmo_i,
  input logic       pb_evt,
  input logic [1:0] mode_o,
  input logic [5:0] func_en_o,
  input logic       clk_sel_o,
  input logic       wake_flag_o
);
  // R2
  full_on_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_pwr_i |=> mode_o == 2'd0);

  // R3
  batt_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !sys_pwr_i && bat_ok_i) |=> mode_o == 2'd1);

  // R6
  forced_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_pwr_i && !bat_ok_i) |=> mode_o == 2'd3);

  // R6
  rest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3 && !sys_pwr_i && !wake_tmo_i && !pb_evt) |=> mode_o == 2'd3);

  // R9
  wake_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_tmo_i |=> wake_flag_o);

  // R10
  rest_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3) |-> func_en_o == 6'h03);

  // R11
  clk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel_o == (mode_o != 2'd0));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sys_pwr_i(sys_pwr_i), .bat_ok_i(bat_ok_i),
  .wake_tmo_i(wake_tmo_i), .pb_evt(pb_evt), .mode_o(mode_o),
  .func_en_o(func_en_o), .clk_sel_o(clk_sel_o), .wake_flag_o(wake_flag_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sys_pwr, bat_ok, pbtn, wake_tmo, bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [1:0] mode;
  logic [5:0] fn_en;
  logic       clk_sel, mpu_run, pb_flag, wake_flag;
  logic [2:0] mpu_div;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sys_pwr_i(sys_pwr), .bat_ok_i(bat_ok),
    .pbtn_i(pbtn), .wake_tmo_i(wake_tmo), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .mode_o(mode),
    .func_en_o(fn_en), .clk_sel_o(clk_sel), .mpu_run_o(mpu_run),
    .mpu_div_o(mpu_div), .pb_flag_o(pb_flag), .wake_flag_o(wake_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic wake_pulse();
    wake_tmo = 1'b1;
    tick(1);
    wake_tmo = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset();
    check("R1 mode", mode, 2'd3);
    check("R1 pb flag", pb_flag, 1'b0);
    check("R1 wake flag", wake_flag, 1'b0);
    check("R1 div", mpu_div, 3'd0);
    check("R1 enables", fn_en, 6'h03);
    check("R1 clk sel", clk_sel, 1'b1);
    check("R1 run", mpu_run, 1'b0);
  endtask

  task automatic t_power_up();
    sys_pwr = 1'b1;
    tick(1);
    check("R2 mode", mode, 2'd0);
    check("R10 full enables", fn_en, 6'h3F);
    check("R11 clk sel full", clk_sel, 1'b0);
    check("R11 run full", mpu_run, 1'b1);
    bus_write(4'h9, 8'h65);
    check("R5 request ignored", mode, 2'd0);
    check("R12 div", mpu_div, 3'd5);
  endtask

  task automatic t_power_loss();
    sys_pwr = 1'b0;
    tick(1);
    check("R3 mode", mode, 2'd1);
    check("R10 batt enables", fn_en, 6'h1F);
    check("R11 clk sel batt", clk_sel, 1'b1);
    check("R11 run batt", mpu_run, 1'b1);
  endtask

  task automatic t_disp_req();
    bus_write(4'h9, 8'h22);
    check("R4 disp", mode, 2'd2);
    check("R12 div", mpu_div, 3'd2);
    check("R10 disp enables", fn_en, 6'h07);
    check("R11 run disp", mpu_run, 1'b0);
    bus_write(4'h9, 8'h40);
    check("R4 ignored in disp", mode, 2'd2);
  endtask

  task automatic t_wake_timer();
    wake_pulse();
    check("R7 wake exit", mode, 2'd1);
    check("R9 wake flag set", wake_flag, 1'b1);
    bus_write(4'h8, 8'h20);
    check("R9 write 1 keeps", wake_flag, 1'b1);
    bus_write(4'h8, 8'h00);
    check("R9 write 0 clears", wake_flag, 1'b0);
    wake_tmo = 1'b1;
    bus_write(4'h8, 8'h00);
    wake_tmo = 1'b0;
    check("R9 set wins", wake_flag, 1'b1);
    check("R7 no change in batt", mode, 2'd1);
    bus_write(4'h8, 8'h00);
    check("R9 cleared", wake_flag, 1'b0);
  endtask

  task automatic t_rest_both();
    bus_write(4'h9, 8'h60);
    check("R4 both bits rest", mode, 2'd3);
    check("R10 rest enables", fn_en, 6'h03);
    bus_write(4'h9, 8'h20);
    check("R4 ignored in rest", mode, 2'd3);
  endtask

  task automatic t_button();
    pbtn = 1'b1;
    tick(2);
    check("R8 not yet", pb_flag, 1'b0);
    check("R7 still rest", mode, 2'd3);
    tick(1);
    check("R8 flag set", pb_flag, 1'b1);
    check("R7 button exit", mode, 2'd1);
    bus_write(4'h8, 8'h00);
    check("R8 cleared", pb_flag, 1'b0);
    tick(5);
    check("R8 held no retrigger", pb_flag, 1'b0);
    pbtn = 1'b0;
    tick(3);
  endtask

  task automatic t_forced_rest();
    bat_ok = 1'b0;
    tick(1);
    check("R6 forced from batt", mode, 2'd3);
    bat_ok = 1'b1;
    tick(6);
    check("R6 stays rest", mode, 2'd3);
    wake_pulse();
    check("R7 wake after forced", mode, 2'd1);
    bus_write(4'h9, 8'h20);
    check("R4 disp again", mode, 2'd2);
    bat_ok = 1'b0;
    tick(1);
    check("R6 forced from disp", mode, 2'd3);
    bat_ok = 1'b1;
    tick(2);
    sys_pwr = 1'b1;
    tick(1);
    check("R2 power from rest", mode, 2'd0);
    bat_ok = 1'b0;
    tick(2);
    check("R2 power beats low battery", mode, 2'd0);
    bat_ok = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; sys_pwr = 1'b0; bat_ok = 1'b1; pbtn = 1'b0; wake_tmo = 1'b0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_power_up();
    t_power_loss();
    t_disp_req();
    t_wake_timer();
    t_rest_both();
    t_button();
    t_forced_rest();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule